// File: doc/BRIEF.md
# Symbol-Correcting Memory ECC Codec

This block protects a 128-bit memory word with 16 check bits, so that the stored unit is 144 bits wide and spans two adjacent 72-bit channels. Bits are grouped into 4-bit symbols. Each symbol maps to one x4 memory device, so a failed device corrupts exactly one symbol. The code repairs any corruption confined to one symbol, whatever the bit pattern. It flags most corruption that spans two symbols as uncorrectable instead of repairing it wrongly.

The encoder is purely combinational. It passes the data through unchanged and appends four check symbols. Each check symbol is a fixed GF(16) linear combination of the 32 data symbols, using the field polynomial x^4+x+1.

The decoder recomputes the check symbols and XORs them with the received ones to form a four-symbol syndrome. It then tests all 36 positions in parallel for a single-symbol match, repairs the matching symbol, and registers the data, a status code and the failing symbol index. Results appear one clock after the input is accepted, and there is no backpressure.

Top module: `symecc_codec`

## Requirements
- R1: Symbol i of a codeword occupies bits [4i+3:4i]. Symbols 0..31 are data and symbols 32..35 are check symbols. `enc_code[127:0]` equals `enc_data` in the same cycle, without a clock.
- R2: A codeword produced by the encoder and decoded unaltered gives status 00 (clean), the original data, and index 0.
- R3: Any nonzero 4-bit error pattern XORed into any one data symbol (0..31) gives status 01 (corrected), index equal to that symbol number, and the original data.
- R4: Any nonzero error pattern confined to one check symbol (32..35) gives status 01, index equal to that symbol number, and unchanged data.
- R5: When the status is 10 (uncorrectable), `dec_data` equals bits [127:0] of the received codeword, unmodified.
- R6: Over 1000 random errors that each hit two distinct symbols with nonzero patterns, at most 40 are reported as status 00 or 01.
- R7: `dec_valid_out` is high exactly one clock after a cycle with `dec_valid_in` high. Data, status and index change only on such cycles and hold otherwise.
- R8: While `rst` is high at a clock edge, `dec_valid_out`, `dec_data`, `dec_status` and `dec_sym_idx` are all cleared to zero.
- R9: `dec_status` never takes the value 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enc_data | input | 128 | Data word to encode |
| enc_code | output | 144 | Encoded word (combinational) |
| dec_valid_in | input | 1 | Codeword on `dec_code` is to be decoded this cycle |
| dec_code | input | 144 | Received codeword |
| dec_valid_out | output | 1 | Decoder outputs carry a new result |
| dec_data | output | 128 | Corrected (or passed-through) data |
| dec_status | output | 2 | 00 clean, 01 corrected, 10 uncorrectable |
| dec_sym_idx | output | 6 | Repaired symbol number (0..35), 0 when none |

## Verification
The pass-through assertions assume that `dec_code` is held stable across the clock edge at which `dec_valid_in` is sampled. The bench keeps to this by changing inputs only on the falling edge. The latency and hold properties assume reset is applied for at least two edges before the first valid input. The bench holds reset for three cycles and keeps `dec_valid_in` low throughout. The bench builds every decoded word from a word the encoder produced, plus a known error mask. The expected repair is therefore fixed by the injected symbol and pattern, with no copy of the check equations.

// File: rtl/symecc_pkg.sv
`timescale 1ns/1ps
package symecc_pkg;
    localparam int SYM_W     = 4;
    localparam int DATA_SYMS = 32;
    localparam int CHK_SYMS  = 4;
    localparam int TOT_SYMS  = DATA_SYMS + CHK_SYMS;
    localparam int DATA_W    = DATA_SYMS * SYM_W;
    localparam int CHK_W     = CHK_SYMS * SYM_W;
    localparam int CODE_W    = DATA_W + CHK_W;
    localparam int IDX_W     = $clog2(TOT_SYMS);
    localparam int GF_ORDER  = (1 << SYM_W) - 1;
    localparam logic [SYM_W-1:0] GF_REDUCE = 4'b0011; // x^4 = x + 1

    typedef enum logic [1:0] {
        ST_CLEAN  = 2'b00,
        ST_FIXED  = 2'b01,
        ST_UNCORR = 2'b10
    } dec_status_e;

    typedef logic [CHK_SYMS-1:0][SYM_W-1:0] syn_t;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        dec_status_e       status;
        logic [IDX_W-1:0]  idx;
    } dec_result_t;

    function automatic logic [SYM_W-1:0] gf_mul(input logic [SYM_W-1:0] x,
                                                 input logic [SYM_W-1:0] y);
        logic [SYM_W-1:0] acc;
        logic [SYM_W-1:0] sh;
        acc = '0;
        sh  = x;
        for (int b = 0; b < SYM_W; b++) begin
            if (y[b]) acc = acc ^ sh;
            sh = sh[SYM_W-1] ? ({sh[SYM_W-2:0], 1'b0} ^ GF_REDUCE)
                             : {sh[SYM_W-2:0], 1'b0};
        end
        return acc;
    endfunction

    function automatic logic [SYM_W-1:0] gf_alpha_pow(input int n);
        logic [SYM_W-1:0] p;
        p = 4'd1;
        for (int k = 0; k < (n % GF_ORDER); k++) p = gf_mul(p, 4'd2);
        return p;
    endfunction

    // Column coefficient of data position pos in syndrome row r.
    function automatic logic [SYM_W-1:0] col_coef(input int pos, input int r);
        int m;
        m = pos % GF_ORDER;
        case (r)
            0:       return 4'd1;
            1:       return gf_alpha_pow(m);
            2:       return gf_alpha_pow(2 * m);
            default: return gf_alpha_pow(pos / GF_ORDER + 3 * m);
        endcase
    endfunction

    function automatic syn_t calc_checks(input logic [DATA_W-1:0] d);
        syn_t chk;
        chk = '0;
        for (int i = 0; i < DATA_SYMS; i++)
            for (int r = 0; r < CHK_SYMS; r++)
                chk[r] = chk[r] ^ gf_mul(col_coef(i, r), d[SYM_W*i +: SYM_W]);
        return chk;
    endfunction
endpackage

// File: rtl/symecc_encoder.sv
`timescale 1ns/1ps
module symecc_encoder
    import symecc_pkg::*;
(
    input  logic [DATA_W-1:0] data_i,
    output logic [CODE_W-1:0] code_o
);
    syn_t chk;

    always_comb begin
        chk    = calc_checks(data_i);
        code_o = {chk, data_i};
    end
endmodule

// File: rtl/symecc_syndrome.sv
`timescale 1ns/1ps
module symecc_syndrome
    import symecc_pkg::*;
(
    input  logic [CODE_W-1:0] code_i,
    output syn_t              syn_o
);
    always_comb begin
        syn_o = calc_checks(code_i[DATA_W-1:0]) ^ syn_t'(code_i[CODE_W-1:DATA_W]);
    end
endmodule

// File: rtl/symecc_locator.sv
`timescale 1ns/1ps
module symecc_locator
    import symecc_pkg::*;
(
    input  syn_t              syn_i,
    input  logic [DATA_W-1:0] data_i,
    output dec_result_t       res_o
);
    logic [TOT_SYMS-1:0] match;
    logic [CHK_W-1:0]    syn_flat;

    assign syn_flat = syn_i;

    for (genvar k = 0; k < TOT_SYMS; k++) begin : g_pos
        if (k < DATA_SYMS) begin : g_data
            localparam logic [SYM_W-1:0] CA = col_coef(k, 1);
            localparam logic [SYM_W-1:0] CB = col_coef(k, 2);
            localparam logic [SYM_W-1:0] CC = col_coef(k, 3);
            assign match[k] = (syn_i[0] != '0)
                           && (syn_i[1] == gf_mul(CA, syn_i[0]))
                           && (syn_i[2] == gf_mul(CB, syn_i[0]))
                           && (syn_i[3] == gf_mul(CC, syn_i[0]));
        end else begin : g_check
            localparam int ROW = k - DATA_SYMS;
            localparam logic [CHK_W-1:0] KEEP = ~(CHK_W'({SYM_W{1'b1}}) << (SYM_W * ROW));
            assign match[k] = (syn_i[ROW] != '0) && ((syn_flat & KEEP) == '0);
        end
    end

    int unsigned      hits;
    logic [IDX_W-1:0] hit_idx;
    logic [DATA_W-1:0] fix_mask;

    always_comb begin
        hits     = 0;
        hit_idx  = '0;
        fix_mask = '0;
        for (int k = 0; k < TOT_SYMS; k++) begin
            if (match[k]) begin
                hits    = hits + 1;
                hit_idx = IDX_W'(k);
            end
        end
        for (int k = 0; k < DATA_SYMS; k++)
            if (match[k]) fix_mask[SYM_W*k +: SYM_W] = syn_i[0];

        res_o.data   = data_i;
        res_o.idx    = '0;
        res_o.status = ST_CLEAN;
        if (syn_flat != '0) begin
            if (hits == 1) begin
                res_o.status = ST_FIXED;
                res_o.idx    = hit_idx;
                res_o.data   = data_i ^ fix_mask;
            end else begin
                res_o.status = ST_UNCORR;
            end
        end
    end
endmodule

// File: rtl/symecc_codec.sv
`timescale 1ns/1ps
module symecc_codec
    import symecc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] enc_data,
    output logic [CODE_W-1:0] enc_code,
    input  logic              dec_valid_in,
    input  logic [CODE_W-1:0] dec_code,
    output logic              dec_valid_out,
    output logic [DATA_W-1:0] dec_data,
    output logic [1:0]        dec_status,
    output logic [IDX_W-1:0]  dec_sym_idx
);
    syn_t        syn;
    dec_result_t res_c;
    dec_result_t res_q;
    logic        vld_q;

    symecc_encoder u_enc (
        .data_i (enc_data),
        .code_o (enc_code)
    );

    symecc_syndrome u_syn (
        .code_i (dec_code),
        .syn_o  (syn)
    );

    symecc_locator u_loc (
        .syn_i  (syn),
        .data_i (dec_code[DATA_W-1:0]),
        .res_o  (res_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= 1'b0;
            res_q <= '0;
        end else begin
            vld_q <= dec_valid_in;
            if (dec_valid_in) res_q <= res_c;
        end
    end

    assign dec_valid_out = vld_q;
    assign dec_data      = res_q.data;
    assign dec_status    = res_q.status;
    assign dec_sym_idx   = res_q.idx;

    // R7
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(dec_valid_in) && !$past(rst)) |-> dec_valid_out);
    // R7
    valid_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(dec_valid_in) |-> !dec_valid_out);
    // R7
    result_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(dec_valid_in) && !$past(rst)) |-> ($stable(dec_data) && $stable(dec_status)));
    // R9
    status_legal_chk: assert property (@(posedge clk) disable iff (rst)
        dec_status != 2'b11);
    // R5
    uncorr_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (dec_valid_out && dec_status == ST_UNCORR) |-> dec_data == $past(dec_code[DATA_W-1:0]));
    // R2
    clean_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (dec_valid_out && dec_status == ST_CLEAN) |-> (dec_data == $past(dec_code[DATA_W-1:0]) && dec_sym_idx == '0));
    // R3
    fixed_idx_range_chk: assert property (@(posedge clk) disable iff (rst)
        (dec_valid_out && dec_status == ST_FIXED) |-> dec_sym_idx < IDX_W'(TOT_SYMS));
endmodule

// File: tb/symecc_codec_tb.sv
`timescale 1ns/1ps
module symecc_codec_tb;
    import symecc_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [DATA_W-1:0] enc_data = '0;
    logic [CODE_W-1:0] enc_code;
    logic              dec_valid_in = 1'b0;
    logic [CODE_W-1:0] dec_code = '0;
    logic              dec_valid_out;
    logic [DATA_W-1:0] dec_data;
    logic [1:0]        dec_status;
    logic [IDX_W-1:0]  dec_sym_idx;

    always #2.5 clk = ~clk;

    symecc_codec u_dut (
        .clk(clk), .rst(rst), .enc_data(enc_data), .enc_code(enc_code),
        .dec_valid_in(dec_valid_in), .dec_code(dec_code),
        .dec_valid_out(dec_valid_out), .dec_data(dec_data),
        .dec_status(dec_status), .dec_sym_idx(dec_sym_idx)
    );

    int  n_chk = 0;
    int  n_fail = 0;
    bit  saw_bad_status = 0;
    bit  done = 0;

    typedef struct packed {
        logic [127:0] data;
        logic [5:0]   pos;
        logic [3:0]   pat;
        logic [1:0]   st;
    } tv_t;

    localparam tv_t TV [8] = '{
        '{128'h0,                                  6'd0,  4'h0, 2'b00},
        '{128'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF, 6'd0,  4'hF, 2'b01},
        '{128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210, 6'd31, 4'h1, 2'b01},
        '{128'hDEAD_BEEF_0000_1111_2222_3333_CAFE_F00D, 6'd15, 4'h8, 2'b01},
        '{128'h5555_AAAA_5555_AAAA_5555_AAAA_5555_AAAA, 6'd32, 4'h6, 2'b01},
        '{128'h8000_0000_0000_0000_0000_0000_0000_0001, 6'd35, 4'hB, 2'b01},
        '{128'h1357_9BDF_2468_ACE0_1357_9BDF_2468_ACE0, 6'd0,  4'h0, 2'b00},
        '{128'h0F0F_0F0F_F0F0_F0F0_3C3C_3C3C_C3C3_C3C3, 6'd16, 4'h7, 2'b01}
    };

    task automatic check(input bit ok, input string tag,
                         input logic [CODE_W-1:0] act, input logic [CODE_W-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic encode(input logic [DATA_W-1:0] d, output logic [CODE_W-1:0] c);
        @(negedge clk);
        enc_data = d;
        #1;
        c = enc_code;
    endtask

    task automatic decode(input logic [CODE_W-1:0] c);
        @(negedge clk);
        dec_code     = c;
        dec_valid_in = 1'b1;
        @(negedge clk);
        dec_valid_in = 1'b0;
        if (dec_status == 2'b11) saw_bad_status = 1;
    endtask

    function automatic logic [CODE_W-1:0] sym_err(input int pos, input logic [3:0] p);
        logic [CODE_W-1:0] e;
        e = '0;
        e[4*pos +: 4] = p;
        return e;
    endfunction

    function automatic logic [DATA_W-1:0] rand_word();
        return {$urandom(), $urandom(), $urandom(), $urandom()};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [CODE_W-1:0] cw;
        logic [CODE_W-1:0] rx;
        logic [DATA_W-1:0] d;
        logic [DATA_W-1:0] held;
        int misc;

        // R8: reset state
        repeat (3) @(negedge clk);
        check(dec_valid_out == 0 && dec_data == '0 && dec_status == 2'b00 && dec_sym_idx == '0,
              "R8 reset", {dec_valid_out, dec_status, dec_sym_idx, dec_data}, '0);
        rst = 1'b0;

        // R1: systematic layout
        d = 128'h0123_4567_89AB_CDEF_0F1E_2D3C_4B5A_6978;
        encode(d, cw);
        check(cw[DATA_W-1:0] == d, "R1 data field", cw, {16'h0, d});

        // Vector table
        foreach (TV[t]) begin
            encode(TV[t].data, cw);
            rx = cw ^ ((TV[t].pat != 0) ? sym_err(int'(TV[t].pos), TV[t].pat) : '0);
            decode(rx);
            check(dec_valid_out && dec_status == TV[t].st && dec_data == TV[t].data
                  && dec_sym_idx == ((TV[t].st == 2'b01) ? TV[t].pos : 6'd0),
                  (TV[t].pos >= 32) ? "R4 table" : (TV[t].st == 2'b00 ? "R2 table" : "R3 table"),
                  {dec_status, dec_sym_idx, dec_data}, {TV[t].st, TV[t].pos, TV[t].data});
        end

        // R2: clean words
        for (int n = 0; n < 4; n++) begin
            d = rand_word();
            encode(d, cw);
            decode(cw);
            check(dec_status == 2'b00 && dec_data == d && dec_sym_idx == 0,
                  "R2 clean", {dec_status, dec_sym_idx, dec_data}, {2'b00, 6'd0, d});
        end

        // R3 / R4: every nonzero pattern in every symbol
        d = rand_word();
        encode(d, cw);
        for (int pos = 0; pos < TOT_SYMS; pos++) begin
            for (int p = 1; p < 16; p++) begin
                decode(cw ^ sym_err(pos, 4'(p)));
                check(dec_status == 2'b01 && dec_sym_idx == 6'(pos) && dec_data == d,
                      (pos < 32) ? "R3 single symbol" : "R4 check symbol",
                      {dec_status, dec_sym_idx, dec_data}, {2'b01, 6'(pos), d});
            end
        end

        // R7: hold without valid
        held = dec_data;
        @(negedge clk);
        dec_code = ~cw;
        @(negedge clk);
        check(dec_valid_out == 0 && dec_data == held, "R7 hold",
              {dec_valid_out, dec_data}, {1'b0, held});

        // R5 / R6: random two-symbol errors
        misc = 0;
        for (int n = 0; n < 1000; n++) begin
            int i;
            int j;
            d = rand_word();
            encode(d, cw);
            i = $urandom_range(0, TOT_SYMS - 1);
            j = $urandom_range(0, TOT_SYMS - 2);
            if (j >= i) j = j + 1;
            rx = cw ^ sym_err(i, 4'($urandom_range(1, 15))) ^ sym_err(j, 4'($urandom_range(1, 15)));
            decode(rx);
            if (dec_status != 2'b10) misc++;
            else check(dec_data == rx[DATA_W-1:0], "R5 passthrough",
                       {16'h0, dec_data}, {16'h0, rx[DATA_W-1:0]});
        end
        check(misc <= 40, "R6 miscorrection bound", CODE_W'(misc), CODE_W'(40));

        // R9
        check(!saw_bad_status, "R9 status encoding", '0, '0);

        // R8: reset mid-run clears outputs
        decode(cw ^ sym_err(3, 4'h5));
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check(dec_valid_out == 0 && dec_data == '0 && dec_status == 2'b00 && dec_sym_idx == '0,
              "R8 reset mid-run", {dec_valid_out, dec_status, dec_sym_idx, dec_data}, '0);
        rst = 1'b0;

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule